// File: doc/BRIEF.md
# Hidden IDE Configuration Bank Unlock Sequencer

This block sits on the device side of a legacy IDE host adapter, at the eight-port task-file window that starts at a base I/O address. Most of the time it forwards every access in that window to the task-file logic without change. It also hides a small bank of timing and configuration registers behind those same addresses. The bank opens only after a fixed knock: two 16-bit reads of window offset 1, then a byte write of 0x03 to offset 2. While the bank is open, an access to base plus an index reaches configuration register `index` and does not reach the task file. A byte write of 0x83 to offset 2 closes the bank again.

The bank holds two timing sets, A and B. Each set has a read-cycle and a write-cycle timing byte. It also holds a control byte, a miscellaneous byte and a read-only strap byte whose bit 0 comes from a pin that reports the bus clock (1 = 25 MHz, 0 = 33 MHz). One bit of the miscellaneous byte chooses which set the timing indices write into. The control byte chooses whether drive 1 runs on its own set. The block outputs the active timing pair for the drive that is currently selected.

Top module: `ide_cfg_unlock`

## Requirements
- R1: The bank opens (`bank_open` = 1 after the edge of the final access) after three consecutive in-window accesses: a word read at offset 1, a second word read at offset 1, then a byte write whose low byte is 0x03 at offset 2.
- R2: If any in-window access is not the next expected knock step, the detector returns to idle. Examples are a byte read at offset 1, a third read, a read at another offset, a different value, or a word-sized write. Accesses outside the window neither advance nor reset the detector.
- R3: While the bank is open, a byte write of 0x83 at offset 2 closes it and is not forwarded. A word-sized write of 0x0083 does not close it.
- R4: While the bank is locked, each in-window access appears on the task-file outputs one cycle later, with `tf_valid` = 1 and the same direction, size and data, and with `tf_offset` = address minus base. While the bank is open, in-window accesses are not forwarded.
- R5: While the bank is locked, no access changes any configuration register.
- R6: Indices while open: 0 is read timing, 1 is write timing, 3 is control and 6 is miscellaneous. All four are read/write on the low byte. Index 5 reads the strap pin in bit 0 with zeros above it, and writes to it are ignored. Indices 2, 4 and 7 read zero.
- R7: Timing writes at indices 0 and 1, and reads of those indices, use set B only when miscellaneous bit 0 = 1 and set-B access is enabled. Otherwise they use set A.
- R8: A byte write of 0xC0 at offset 3 while the bank is locked enables set-B access. The write is still forwarded. The enable stays set until reset.
- R9: `act_rd_tim`/`act_wr_tim` show set B when `drv_sel` = 1 and the control register holds exactly 0x85. Otherwise they show set A. The outputs are registered and follow a change one cycle later.
- R10: An in-window read returns `bus_rvalid` = 1 with its data two cycles after it is accepted. Forwarded reads return `tf_rdata`, and configuration reads return the register zero-extended. Out-of-window accesses produce no forward and no `bus_rvalid`.
- R11: After reset the bank is locked, every configuration register is zero, set-B access is disabled, and all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Host access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | 1 = 16-bit access, 0 = byte |
| bus_addr | input | ADDR_W | I/O address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data |
| bus_rvalid | output | 1 | Read data valid |
| strap_slow | input | 1 | Bus clock strap, 1 = 25 MHz |
| drv_sel | input | 1 | Drive currently addressed (0 or 1) |
| tf_valid | output | 1 | Forwarded task-file access strobe |
| tf_wr | output | 1 | Forwarded direction |
| tf_word | output | 1 | Forwarded size |
| tf_offset | output | 3 | Forwarded port offset |
| tf_wdata | output | DATA_W | Forwarded write data |
| tf_rdata | input | DATA_W | Task-file read data |
| bank_open | output | 1 | Configuration bank unlocked |
| act_rd_tim | output | REG_W | Active read-cycle timing |
| act_wr_tim | output | REG_W | Active write-cycle timing |

## Verification
The bench sends near-miss knocks: a byte-sized read in place of a word read, a third read, a stray read at another offset, a wrong key, and a word-sized key write. A detector that only counts reads, or that ignores access size, would open on one of these. The bench also sends a word-sized 0x0083 while the bank is open, which catches a relock decoder that ignores size. The bench writes registers while the bank is locked and then reads them back after unlocking, which shows whether the hidden bank leaks locked traffic. It programs set B both before and after the enable write, so it finds a design that lets miscellaneous bit 0 choose set B without the enable. It loads control with 0x84 as well as 0x85, so it finds a pairing decode that tests only some bits.

// File: rtl/ide_cfg_unlock_pkg.sv
package ide_cfg_unlock_pkg;

  typedef enum logic [1:0] {
    KN_IDLE = 2'd0,
    KN_RD1  = 2'd1,
    KN_RD2  = 2'd2,
    KN_OPEN = 2'd3
  } knock_st_e;

  localparam int unsigned OFF_W = 3;

  localparam logic [OFF_W-1:0] OFF_KNOCK_RD = 3'd1;
  localparam logic [OFF_W-1:0] OFF_KNOCK_WR = 3'd2;
  localparam logic [OFF_W-1:0] OFF_SETB     = 3'd3;

  localparam logic [7:0] KEY_OPEN    = 8'h03;
  localparam logic [7:0] KEY_CLOSE   = 8'h83;
  localparam logic [7:0] KEY_SETB    = 8'hC0;
  localparam logic [7:0] KEY_PAIRMAP = 8'h85;

  localparam logic [OFF_W-1:0] IDX_RDTIM = 3'd0;
  localparam logic [OFF_W-1:0] IDX_WRTIM = 3'd1;
  localparam logic [OFF_W-1:0] IDX_CTRL  = 3'd3;
  localparam logic [OFF_W-1:0] IDX_STRAP = 3'd5;
  localparam logic [OFF_W-1:0] IDX_MISC  = 3'd6;

endpackage

// File: rtl/ide_cfg_knock.sv
module ide_cfg_knock
  import ide_cfg_unlock_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             acc,
  input  logic             wr,
  input  logic             word,
  input  logic [OFF_W-1:0] off,
  input  logic [7:0]       wbyte,
  output logic             open
);

  knock_st_e st_q, st_n;

  logic step_rd, step_key, step_close;

  assign step_rd    = !wr && word && (off == OFF_KNOCK_RD);
  assign step_key   = wr && !word && (off == OFF_KNOCK_WR) && (wbyte == KEY_OPEN);
  assign step_close = wr && !word && (off == OFF_KNOCK_WR) && (wbyte == KEY_CLOSE);

  always_comb begin
    st_n = st_q;
    if (acc) begin
      unique case (st_q)
        KN_IDLE: st_n = step_rd  ? KN_RD1  : KN_IDLE;
        KN_RD1:  st_n = step_rd  ? KN_RD2  : KN_IDLE;
        KN_RD2:  st_n = step_key ? KN_OPEN : KN_IDLE;
        KN_OPEN: st_n = step_close ? KN_IDLE : KN_OPEN;
        default: st_n = KN_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= KN_IDLE;
    else     st_q <= st_n;
  end

  assign open = (st_q == KN_OPEN);

  AST_OPEN_NEEDS_KEY: assert property (@(posedge clk) disable iff (rst)
    $rose(open) |-> $past(acc && wr && !word && off == OFF_KNOCK_WR && wbyte == KEY_OPEN)); // R1

  AST_RELOCK: assert property (@(posedge clk) disable iff (rst)
    (open && acc && step_close) |=> !open); // R3

endmodule

// File: rtl/ide_cfg_file.sv
module ide_cfg_file
  import ide_cfg_unlock_pkg::*;
#(
  parameter int unsigned REG_W = 8,
  parameter int unsigned NSETS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [OFF_W-1:0] idx,
  input  logic [REG_W-1:0] wdata,
  input  logic             strap,
  input  logic             setb_arm,
  input  logic             drv_sel,
  output logic [REG_W-1:0] rd_mux,
  output logic [REG_W-1:0] act_rd_tim,
  output logic [REG_W-1:0] act_wr_tim,
  output logic [REG_W-1:0] ctrl_q,
  output logic [REG_W-1:0] misc_q
);

  localparam int unsigned SET_W = (NSETS > 1) ? $clog2(NSETS) : 1;

  logic [REG_W-1:0] rd_tim [NSETS];
  logic [REG_W-1:0] wr_tim [NSETS];
  logic             setb_en;
  logic [SET_W-1:0] wsel, dsel;

  // Host-side set choice needs both the select bit and the enable.
  assign wsel = SET_W'(misc_q[0] & setb_en);
  // Drive-side set choice needs the exact pairing value in control.
  assign dsel = SET_W'(drv_sel & (ctrl_q == REG_W'(KEY_PAIRMAP)));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NSETS; s++) begin
        rd_tim[s] <= '0;
        wr_tim[s] <= '0;
      end
    end else if (wr_en) begin
      for (int s = 0; s < NSETS; s++) begin
        if (wsel == SET_W'(s)) begin
          if (idx == IDX_RDTIM) rd_tim[s] <= wdata;
          if (idx == IDX_WRTIM) wr_tim[s] <= wdata;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      misc_q  <= '0;
      setb_en <= 1'b0;
    end else begin
      if (wr_en && idx == IDX_CTRL) ctrl_q <= wdata;
      if (wr_en && idx == IDX_MISC) misc_q <= wdata;
      if (setb_arm)                 setb_en <= 1'b1;
    end
  end

  always_comb begin
    unique case (idx)
      IDX_RDTIM: rd_mux = rd_tim[wsel];
      IDX_WRTIM: rd_mux = wr_tim[wsel];
      IDX_CTRL:  rd_mux = ctrl_q;
      IDX_STRAP: rd_mux = REG_W'(strap);
      IDX_MISC:  rd_mux = misc_q;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_rd_tim <= '0;
      act_wr_tim <= '0;
    end else begin
      act_rd_tim <= rd_tim[dsel];
      act_wr_tim <= wr_tim[dsel];
    end
  end

  AST_SETB_STICKY: assert property (@(posedge clk) disable iff (rst)
    setb_en |=> setb_en); // R8

endmodule

// File: rtl/ide_cfg_unlock.sv
module ide_cfg_unlock
  import ide_cfg_unlock_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned REG_W     = 8,
  parameter int unsigned NSETS     = 2,
  parameter logic [15:0] BASE_ADDR = 16'h01F0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_wr,
  input  logic              bus_word,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  input  logic              strap_slow,
  input  logic              drv_sel,
  output logic              tf_valid,
  output logic              tf_wr,
  output logic              tf_word,
  output logic [2:0]        tf_offset,
  output logic [DATA_W-1:0] tf_wdata,
  input  logic [DATA_W-1:0] tf_rdata,
  output logic              bank_open,
  output logic [REG_W-1:0]  act_rd_tim,
  output logic [REG_W-1:0]  act_wr_tim
);

  localparam int unsigned WIN = 1 << OFF_W;

  logic [ADDR_W-1:0] off_full;
  logic [OFF_W-1:0]  off;
  logic              in_win, acc, setb_arm, cfg_wr;
  logic [REG_W-1:0]  cfg_rd, ctrl_w, misc_w;

  assign off_full = bus_addr - ADDR_W'(BASE_ADDR);
  assign in_win   = off_full < ADDR_W'(WIN);
  assign off      = off_full[OFF_W-1:0];
  assign acc      = bus_valid && in_win;
  assign cfg_wr   = acc && bank_open && bus_wr;
  assign setb_arm = acc && !bank_open && bus_wr && !bus_word &&
                    (off == OFF_SETB) && (bus_wdata[7:0] == KEY_SETB);

  ide_cfg_knock u_knock (
    .clk   (clk),
    .rst   (rst),
    .acc   (acc),
    .wr    (bus_wr),
    .word  (bus_word),
    .off   (off),
    .wbyte (bus_wdata[7:0]),
    .open  (bank_open)
  );

  ide_cfg_file #(
    .REG_W (REG_W),
    .NSETS (NSETS)
  ) u_file (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (cfg_wr),
    .idx        (off),
    .wdata      (bus_wdata[REG_W-1:0]),
    .strap      (strap_slow),
    .setb_arm   (setb_arm),
    .drv_sel    (drv_sel),
    .rd_mux     (cfg_rd),
    .act_rd_tim (act_rd_tim),
    .act_wr_tim (act_wr_tim),
    .ctrl_q     (ctrl_w),
    .misc_q     (misc_w)
  );

  // Forward stage toward the task file.
  always_ff @(posedge clk) begin
    if (rst) begin
      tf_valid  <= 1'b0;
      tf_wr     <= 1'b0;
      tf_word   <= 1'b0;
      tf_offset <= '0;
      tf_wdata  <= '0;
    end else begin
      tf_valid <= acc && !bank_open;
      if (acc) begin
        tf_wr     <= bus_wr;
        tf_word   <= bus_word;
        tf_offset <= off;
        tf_wdata  <= bus_wdata;
      end
    end
  end

  // Two-stage read return, same latency for both sources.
  logic             s1_rd, s1_cfg;
  logic [REG_W-1:0] s1_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_rd      <= 1'b0;
      s1_cfg     <= 1'b0;
      s1_data    <= '0;
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      s1_rd      <= acc && !bus_wr;
      s1_cfg     <= bank_open;
      s1_data    <= cfg_rd;
      bus_rvalid <= s1_rd;
      if (!s1_rd)      bus_rdata <= '0;
      else if (s1_cfg) bus_rdata <= DATA_W'(s1_data);
      else             bus_rdata <= tf_rdata;
    end
  end

  AST_TF_QUIET_OPEN: assert property (@(posedge clk) disable iff (rst)
    (acc && bank_open) |=> !tf_valid); // R4

  AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (rst)
    (acc && !bank_open) |=> ($stable(ctrl_w) && $stable(misc_w))); // R5

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (acc && !bus_wr) |=> ##1 bus_rvalid); // R10

  AST_NO_STRAY_RVALID: assert property (@(posedge clk) disable iff (rst)
    (!acc || bus_wr) |=> ##1 !bus_rvalid); // R10

endmodule

// File: tb/ide_cfg_unlock_tb.sv
module ide_cfg_unlock_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] B = 16'h01F0;

  logic        clk = 1'b0;
  logic        rst;
  logic        bus_valid, bus_wr, bus_word;
  logic [15:0] bus_addr, bus_wdata, bus_rdata, tf_wdata, tf_rdata;
  logic        bus_rvalid, strap_slow, drv_sel;
  logic        tf_valid, tf_wr, tf_word, bank_open;
  logic [2:0]  tf_offset;
  logic [7:0]  act_rd_tim, act_wr_tim;

  int nchk = 0;
  int nfail = 0;

  // Captured per access
  logic        c_tfv, c_tfwr, c_tfword, c_rv;
  logic [2:0]  c_tfoff;
  logic [15:0] c_tfwd, c_rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign tf_rdata = {8'hD0, 5'd0, tf_offset};

  ide_cfg_unlock u_dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_wr(bus_wr), .bus_word(bus_word),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .strap_slow(strap_slow), .drv_sel(drv_sel), .tf_valid(tf_valid), .tf_wr(tf_wr),
    .tf_word(tf_word), .tf_offset(tf_offset), .tf_wdata(tf_wdata), .tf_rdata(tf_rdata),
    .bank_open(bank_open), .act_rd_tim(act_rd_tim), .act_wr_tim(act_wr_tim)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic word, input logic [15:0] addr, input logic [15:0] data);
    @(negedge clk);
    bus_valid = 1'b1; bus_wr = wr; bus_word = word; bus_addr = addr; bus_wdata = data;
    @(negedge clk);
    bus_valid = 1'b0;
    c_tfv = tf_valid; c_tfwr = tf_wr; c_tfword = tf_word; c_tfoff = tf_offset; c_tfwd = tf_wdata;
    @(negedge clk);
    c_rv = bus_rvalid; c_rd = bus_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic unlock();
    acc(1'b0, 1'b1, B + 16'd1, 16'h0);
    acc(1'b0, 1'b1, B + 16'd1, 16'h0);
    acc(1'b1, 1'b0, B + 16'd2, 16'h0003);
  endtask

  task automatic relock();
    acc(1'b1, 1'b0, B + 16'd2, 16'h0083);
  endtask

  task automatic cfg_rd(input int idx, input logic [15:0] exp, input string req, input string what);
    acc(1'b0, 1'b0, B + 16'(idx), 16'h0);
    chk(req, what, {c_rv, c_rd}, {1'b1, exp});
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    chk("R11", "locked after reset", bank_open, 0);
    chk("R11", "tf_valid/rvalid idle", {tf_valid, bus_rvalid}, 0);
    chk("R11", "active timing zero", {act_rd_tim, act_wr_tim}, 0);
  endtask

  task automatic t_passthrough();
    acc(1'b0, 1'b1, B + 16'd7, 16'h0);
    chk("R4", "locked read forwarded", {c_tfv, c_tfwr, c_tfword, c_tfoff}, {1'b1, 1'b0, 1'b1, 3'd7});
    chk("R10", "forwarded read data", {c_rv, c_rd}, {1'b1, 16'hD007});
    acc(1'b1, 1'b0, B + 16'd6, 16'h00A0);
    chk("R4", "locked write forwarded", {c_tfv, c_tfwr, c_tfword, c_tfoff, c_tfwd}, {1'b1, 1'b1, 1'b0, 3'd6, 16'h00A0});
    chk("R10", "no rvalid for write", c_rv, 0);
  endtask

  task automatic t_outside();
    acc(1'b0, 1'b1, B - 16'd1, 16'h0);
    chk("R10", "below window ignored", {c_tfv, c_rv}, 0);
    acc(1'b0, 1'b1, B + 16'd8, 16'h0);
    chk("R10", "above window ignored", {c_tfv, c_rv}, 0);
    // Out-of-window access between knock steps must not break it (R2)
    acc(1'b0, 1'b1, B + 16'd1, 16'h0);
    acc(1'b0, 1'b1, B + 16'd9, 16'h0);
    acc(1'b0, 1'b1, B + 16'd1, 16'h0);
    acc(1'b1, 1'b0, B + 16'd2, 16'h0003);
    chk("R2", "outside access leaves detector", bank_open, 1);
    relock();
  endtask

  task automatic t_locked_ignore();
    acc(1'b1, 1'b0, B + 16'd0, 16'h0077);
    acc(1'b1, 1'b0, B + 16'd3, 16'h0055);
    acc(1'b1, 1'b1, B + 16'd6, 16'h0066);
    unlock();
    cfg_rd(0, 16'h0000, "R5", "read timing untouched while locked");
    cfg_rd(3, 16'h0000, "R5", "control untouched while locked");
    cfg_rd(6, 16'h0000, "R5", "misc untouched while locked");
    relock();
  endtask

  task automatic t_unlock_map();
    unlock();
    chk("R1", "knock opens bank", bank_open, 1);
    strap_slow = 1'b1;
    cfg_rd(5, 16'h0001, "R6", "strap 25 MHz");
    acc(1'b1, 1'b0, B + 16'd5, 16'h00FF);
    cfg_rd(5, 16'h0001, "R6", "strap write ignored");
    strap_slow = 1'b0;
    cfg_rd(5, 16'h0000, "R6", "strap 33 MHz");
    acc(1'b1, 1'b0, B + 16'd3, 16'h005A);
    chk("R4", "open write not forwarded", c_tfv, 0);
    cfg_rd(3, 16'h005A, "R6", "control readback");
    chk("R4", "open read not forwarded", c_tfv, 0);
    acc(1'b1, 1'b0, B + 16'd6, 16'h003C);
    cfg_rd(6, 16'h003C, "R6", "misc readback");
    cfg_rd(2, 16'h0000, "R6", "index 2 reads zero");
    cfg_rd(4, 16'h0000, "R6", "index 4 reads zero");
    cfg_rd(7, 16'h0000, "R6", "index 7 reads zero");
    chk("R6", "read of index 2 keeps bank open", bank_open, 1);
    acc(1'b1, 1'b0, B + 16'd6, 16'h0000);
    acc(1'b1, 1'b0, B + 16'd3, 16'h0000);
  endtask

  task automatic t_relock();
    acc(1'b1, 1'b1, B + 16'd2, 16'h0083);
    chk("R3", "word 0x0083 does not relock", bank_open, 1);
    relock();
    chk("R3", "byte 0x83 relocks", bank_open, 0);
    chk("R3", "relock write not forwarded", c_tfv, 0);
    acc(1'b0, 1'b0, B + 16'd2, 16'h0);
    chk("R3", "ports forward after relock", {c_tfv, c_rd}, {1'b1, 16'hD002});
  endtask

  task automatic t_broken();
    acc(1'b0, 1'b1, B + 16'd1, 16'h0);
    acc(1'b0, 1'b0, B + 16'd1, 16'h0);
    acc(1'b0, 1'b1, B + 16'd1, 16'h0);
    acc(1'b1, 1'b0, B + 16'd2, 16'h0003);
    chk("R2", "byte read breaks knock", bank_open, 0);
    acc(1'b0, 1'b1, B + 16'd1, 16'h0);
    acc(1'b0, 1'b1, B + 16'd1, 16'h0);
    acc(1'b0, 1'b1, B + 16'd1, 16'h0);
    acc(1'b1, 1'b0, B + 16'd2, 16'h0003);
    chk("R2", "third read breaks knock", bank_open, 0);
    acc(1'b0, 1'b1, B + 16'd1, 16'h0);
    acc(1'b0, 1'b1, B + 16'd1, 16'h0);
    acc(1'b0, 1'b1, B + 16'd7, 16'h0);
    acc(1'b1, 1'b0, B + 16'd2, 16'h0003);
    chk("R2", "stray offset breaks knock", bank_open, 0);
    acc(1'b0, 1'b1, B + 16'd1, 16'h0);
    acc(1'b0, 1'b1, B + 16'd1, 16'h0);
    acc(1'b1, 1'b0, B + 16'd2, 16'h0004);
    chk("R2", "wrong key keeps locked", bank_open, 0);
    acc(1'b0, 1'b1, B + 16'd1, 16'h0);
    acc(1'b0, 1'b1, B + 16'd1, 16'h0);
    acc(1'b1, 1'b1, B + 16'd2, 16'h0003);
    chk("R2", "word-sized key keeps locked", bank_open, 0);
    unlock();
    chk("R1", "clean knock after misses opens", bank_open, 1);
    relock();
  endtask

  task automatic t_setb();
    do_reset();
    unlock();
    acc(1'b1, 1'b0, B + 16'd6, 16'h0001);
    acc(1'b1, 1'b0, B + 16'd0, 16'h0011);
    acc(1'b1, 1'b0, B + 16'd1, 16'h0022);
    acc(1'b1, 1'b0, B + 16'd6, 16'h0000);
    cfg_rd(0, 16'h0011, "R7", "set A used without enable");
    cfg_rd(1, 16'h0022, "R7", "set A write timing");
    acc(1'b1, 1'b0, B + 16'd6, 16'h0001);
    relock();
    acc(1'b1, 1'b0, B + 16'd3, 16'h00C0);
    chk("R8", "enable write forwarded", {c_tfv, c_tfoff, c_tfwd}, {1'b1, 3'd3, 16'h00C0});
    unlock();
    cfg_rd(0, 16'h0000, "R8", "set B visible after enable");
    acc(1'b1, 1'b0, B + 16'd0, 16'h0033);
    acc(1'b1, 1'b0, B + 16'd1, 16'h0044);
    acc(1'b1, 1'b0, B + 16'd6, 16'h0000);
    cfg_rd(0, 16'h0011, "R7", "misc0=0 selects A");
    cfg_rd(1, 16'h0022, "R7", "set A intact");
    relock();
    unlock();
    acc(1'b1, 1'b0, B + 16'd6, 16'h0001);
    cfg_rd(0, 16'h0033, "R8", "enable sticky across relock");
    cfg_rd(1, 16'h0044, "R7", "set B write timing");
  endtask

  task automatic t_drive_map();
    drv_sel = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9", "drive1 on A without pairing", {act_rd_tim, act_wr_tim}, 16'h1122);
    acc(1'b1, 1'b0, B + 16'd3, 16'h0085);
    chk("R9", "drive1 on B with 0x85", {act_rd_tim, act_wr_tim}, 16'h3344);
    drv_sel = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9", "drive0 on A with 0x85", {act_rd_tim, act_wr_tim}, 16'h1122);
    drv_sel = 1'b1;
    acc(1'b1, 1'b0, B + 16'd3, 16'h0084);
    chk("R9", "0x84 is not pairing", {act_rd_tim, act_wr_tim}, 16'h1122);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog all: actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    rst = 1'b1; bus_valid = 1'b0; bus_wr = 1'b0; bus_word = 1'b0;
    bus_addr = '0; bus_wdata = '0; strap_slow = 1'b0; drv_sel = 1'b0;
    t_reset();
    t_passthrough();
    t_outside();
    t_locked_ignore();
    t_unlock_map();
    t_relock();
    t_broken();
    t_setb();
    t_drive_map();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule